// File: doc/BRIEF.md
# Associative Search Engine with Bit-Parallel and Bit-Serial Modes

This block holds a small content-addressable table of `WORDS` entries, each `BITS` wide. A host fills the table through a write port. It loads a search pattern and a column-enable mask, then launches a search. The search marks, in a one-bit-per-entry hit vector, every entry that agrees with the pattern on each enabled column. Columns whose enable bit is clear play no part in the result.

A search runs in one of two modes. The fast mode compares all enabled columns of all entries in a single cycle. The slow mode sets every hit bit and then visits one column per cycle, from column 0 upward. At each enabled column it knocks out the entries that disagree with the pattern, so it needs only one column of comparators.

When a new search is launched, the previous hit vector is kept as a history vector. A priority encoder reports the lowest-numbered hit and whether any hit exists. That index can be fed back to the read port to fetch the matching entry.

Top module: `assoc_search`

## Requirements
- R1: After reset the hit vector, history vector, `busy`, `done`, `any_hit` and `first_hit` are all zero.
- R2: A write with `wr_en` high stores `wr_data` at `wr_addr` on the clock edge. `rd_data` shows the entry at `rd_addr` combinationally.
- R3: A launch with `serial_mode` = 0 updates the hit vector at the launch edge. Bit w is 1 exactly when entry w equals the pattern on every column whose mask bit is 1. `done` is high for the cycle after the launch edge.
- R4: Columns with mask bit 0 never influence a hit. An all-zero mask makes every hit bit 1 in both modes.
- R5: A launch with `serial_mode` = 1 raises `busy` for exactly `BITS` cycles. `done` is then high in the first cycle with `busy` low, and the hit vector equals the single-cycle result for the same pattern, mask and table.
- R6: During a bit-serial search the hit vector is all ones in the first busy cycle, and no hit bit is ever set while `busy` is high.
- R7: On every accepted launch, the history vector takes the hit vector held just before that launch.
- R8: While `busy` is high, `start`, `pat_load` and `mask_load` are ignored. No extra `done` pulse appears, and later searches use the pattern and mask loaded before the ignored commands.
- R9: `any_hit` is 1 exactly when some hit bit is set. `first_hit` is the lowest set index, or 0 when none is set.
- R10: Driving `rd_addr` with `first_hit` returns the stored matching entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | $clog2(WORDS) | Table write index |
| wr_data | input | BITS | Entry value to write |
| rd_addr | input | $clog2(WORDS) | Table read index |
| rd_data | output | BITS | Entry at `rd_addr` |
| pat_load | input | 1 | Load search pattern |
| pat_data | input | BITS | Search pattern value |
| mask_load | input | 1 | Load column-enable mask |
| mask_data | input | BITS | Mask value, 1 = column takes part |
| start | input | 1 | Launch a search when idle |
| serial_mode | input | 1 | 0 = single-cycle search, 1 = one column per cycle |
| busy | output | 1 | Bit-serial search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| hit_vec | output | WORDS | Current per-entry hit vector |
| hist_vec | output | WORDS | Hit vector before the latest launch |
| any_hit | output | 1 | At least one hit bit set |
| first_hit | output | $clog2(WORDS) | Lowest index with a hit |

## Verification
The table holds two identical entries and a third that differs from them only in column 0. A full-mask search therefore shows two hits, and clearing mask bit 0 adds the third entry, which separates masked from unmasked comparison. Each pattern and mask pair is searched in both modes, so a wrong column order or a skipped column in the serial sweep disagrees with the single-cycle result. An all-zero mask, a pattern absent from the table and a half mask cover the all-hit, no-hit and partial cases of the encoder. A launch and a pattern load issued mid-sweep show whether commands given while busy leak into the result.

// File: rtl/assoc_pkg.sv
package assoc_pkg;
   typedef enum logic {
      SRCH_PAR = 1'b0,
      SRCH_SER = 1'b1
   } srch_mode_e;
endpackage

// File: rtl/assoc_array.sv
module assoc_array #(
   parameter int WORDS = 16,
   parameter int BITS  = 8,
   localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1,
   localparam int SW   = (BITS > 1) ? $clog2(BITS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [BITS-1:0]  wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [BITS-1:0]  rd_data,
   input  logic [BITS-1:0]  pat,
   input  logic [BITS-1:0]  mask,
   input  logic [SW-1:0]    col_sel,
   output logic [WORDS-1:0] par_hit,
   output logic [WORDS-1:0] col_bits
);
   logic [BITS-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem[rd_addr];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [BITS-1:0] diff;
      assign diff        = (mem[w] ^ pat) & mask;
      assign par_hit[w]  = ~|diff;
      assign col_bits[w] = mem[w][col_sel];
   end

   // R2: a write lands in the addressed entry
   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/assoc_seq.sv
module assoc_seq
   import assoc_pkg::*;
#(
   parameter int WORDS = 16,
   parameter int BITS  = 8,
   localparam int SW   = (BITS > 1) ? $clog2(BITS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  srch_mode_e       mode,
   input  logic             pat_load,
   input  logic [BITS-1:0]  pat_data,
   input  logic             mask_load,
   input  logic [BITS-1:0]  mask_data,
   input  logic [WORDS-1:0] par_hit,
   input  logic [WORDS-1:0] col_bits,
   output logic [BITS-1:0]  pat,
   output logic [BITS-1:0]  mask,
   output logic [SW-1:0]    col_sel,
   output logic [WORDS-1:0] ind,
   output logic [WORDS-1:0] tmp,
   output logic             busy,
   output logic             done
);
   localparam logic [SW-1:0] LAST_COL = SW'(BITS - 1);

   logic [SW-1:0]    col;
   logic [WORDS-1:0] keep;

   // entries whose bit in the current column agrees with the pattern
   assign keep    = ~(col_bits ^ {WORDS{pat[col]}});
   assign col_sel = col;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pat  <= '0;
         mask <= '0;
         ind  <= '0;
         tmp  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
         col  <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (pat_load)  pat  <= pat_data;
            if (mask_load) mask <= mask_data;
         end
         if (start && !busy) begin
            tmp <= ind;
            if (mode == SRCH_SER) begin
               ind  <= '1;
               busy <= 1'b1;
               col  <= '0;
            end else begin
               ind  <= par_hit;
               done <= 1'b1;
            end
         end else if (busy) begin
            if (mask[col]) ind <= ind & keep;
            if (col == LAST_COL) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               col <= col + SW'(1);
            end
         end
      end
   end

   // R6: the sweep only ever clears hit bits
   p_ind_only_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((ind & ~$past(ind)) == '0));
   // R7: launch copies the old hit vector into history
   p_tmp_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> tmp == $past(ind));
   // R8: pattern and mask frozen across a sweep
   p_hold_regs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(pat) && $stable(mask)));
   // R5: end pulse only when idle
   p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R5: a sweep ending always raises done
   p_fall_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
endmodule

// File: rtl/assoc_prio.sv
module assoc_prio #(
   parameter int WORDS = 16,
   localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic [WORDS-1:0] vec,
   output logic             any,
   output logic [AW-1:0]    idx
);
   always_comb begin
      idx = '0;
      for (int w = WORDS - 1; w >= 0; w--) begin
         if (vec[w]) idx = AW'(w);
      end
   end
   assign any = |vec;
endmodule

// File: rtl/assoc_search.sv
module assoc_search
   import assoc_pkg::*;
#(
   parameter int WORDS = 16,
   parameter int BITS  = 8,
   localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1,
   localparam int SW   = (BITS > 1) ? $clog2(BITS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [BITS-1:0]  wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [BITS-1:0]  rd_data,
   input  logic             pat_load,
   input  logic [BITS-1:0]  pat_data,
   input  logic             mask_load,
   input  logic [BITS-1:0]  mask_data,
   input  logic             start,
   input  logic             serial_mode,
   output logic             busy,
   output logic             done,
   output logic [WORDS-1:0] hit_vec,
   output logic [WORDS-1:0] hist_vec,
   output logic             any_hit,
   output logic [AW-1:0]    first_hit
);
   if (WORDS < 2) begin : g_bad_words
      $error("assoc_search: WORDS must be at least 2");
   end
   if (BITS < 2) begin : g_bad_bits
      $error("assoc_search: BITS must be at least 2");
   end

   logic [BITS-1:0]  pat, mask;
   logic [SW-1:0]    col_sel;
   logic [WORDS-1:0] par_hit, col_bits;
   srch_mode_e       mode;

   assign mode = serial_mode ? SRCH_SER : SRCH_PAR;

   assoc_array #(.WORDS(WORDS), .BITS(BITS)) u_array (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .pat(pat), .mask(mask), .col_sel(col_sel),
      .par_hit(par_hit), .col_bits(col_bits)
   );

   assoc_seq #(.WORDS(WORDS), .BITS(BITS)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start(start), .mode(mode),
      .pat_load(pat_load), .pat_data(pat_data),
      .mask_load(mask_load), .mask_data(mask_data),
      .par_hit(par_hit), .col_bits(col_bits),
      .pat(pat), .mask(mask), .col_sel(col_sel),
      .ind(hit_vec), .tmp(hist_vec),
      .busy(busy), .done(done)
   );

   assoc_prio #(.WORDS(WORDS)) u_prio (
      .vec(hit_vec), .any(any_hit), .idx(first_hit)
   );

   logic [WORDS-1:0] below;
   assign below = (WORDS'(1) << first_hit) - WORDS'(1);

   // R9: encoder points at the lowest set hit bit
   p_first_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      any_hit |-> (hit_vec[first_hit] && ((hit_vec & below) == '0)));
   // R9: no hit means zero index and empty vector
   p_none_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !any_hit |-> (first_hit == '0 && hit_vec == '0));
   // R4: an all-zero mask at a single-cycle launch gives all hits
   p_nomask_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !serial_mode && mask == '0) |=> hit_vec == '1);
endmodule

// File: tb/assoc_search_bench.sv
module assoc_search_bench;
   localparam int W  = 16;
   localparam int B  = 8;
   localparam int AW = $clog2(W);

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, wr_en, pat_load, mask_load, start, serial_mode;
   logic [AW-1:0] wr_addr, rd_addr, first_hit;
   logic [B-1:0]  wr_data, rd_data, pat_data, mask_data;
   logic          busy, done, any_hit;
   logic [W-1:0]  hit_vec, hist_vec;

   assoc_search #(.WORDS(W), .BITS(B)) u_assoc_search (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .pat_load(pat_load), .pat_data(pat_data), .mask_load(mask_load),
      .mask_data(mask_data), .start(start), .serial_mode(serial_mode),
      .busy(busy), .done(done), .hit_vec(hit_vec), .hist_vec(hist_vec),
      .any_hit(any_hit), .first_hit(first_hit)
   );

   typedef struct packed {
      logic [W-1:0] hits;
      logic [W-1:0] hist;
   } exp_t;

   exp_t         exp_q[$];
   int           nchk = 0, nfail = 0;
   logic [B-1:0] m_mem [W];
   logic [B-1:0] m_pat = '0, m_mask = '0;
   logic [W-1:0] m_ind = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic logic [W-1:0] model_hits();
      logic [W-1:0] r;
      for (int w = 0; w < W; w++) r[w] = (((m_mem[w] ^ m_pat) & m_mask) == '0);
      return r;
   endfunction

   function automatic int lowest(input logic [W-1:0] v);
      for (int w = 0; w < W; w++) if (v[w]) return w;
      return 0;
   endfunction

   // monitor: compare every end-of-search pulse against the scoreboard
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8 extra done", 32'(hit_vec), 32'h0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(hit_vec == e.hits, "R3/R4/R5 hit vector", 32'(hit_vec), 32'(e.hits));
            chk(hist_vec == e.hist, "R7 history", 32'(hist_vec), 32'(e.hist));
            chk(any_hit == (e.hits != '0), "R9 any", 32'(any_hit), 32'(e.hits != '0));
            chk(32'(first_hit) == 32'(lowest(e.hits)), "R9 first", 32'(first_hit), 32'(lowest(e.hits)));
         end
      end
   end

   task automatic load(input logic [B-1:0] p, input logic [B-1:0] m);
      pat_load = 1'b1; pat_data = p; mask_load = 1'b1; mask_data = m;
      @(negedge clk);
      pat_load = 1'b0; mask_load = 1'b0;
      m_pat = p; m_mask = m;
   endtask

   task automatic search(input bit ser);
      exp_t e;
      int n;
      e.hits = model_hits();
      e.hist = m_ind;
      exp_q.push_back(e);
      m_ind = e.hits;
      start = 1'b1; serial_mode = ser;
      @(negedge clk);
      start = 1'b0;
      if (!ser) begin
         chk(done == 1'b1, "R3 done timing", 32'(done), 32'h1);
      end else begin
         chk(hit_vec == '1, "R6 all ones first", 32'(hit_vec), 32'hFFFF);
         n = 0;
         while (busy && n < 100) begin
            n++;
            @(negedge clk);
         end
         chk(n == B, "R5 busy length", 32'(n), 32'(B));
         chk(done == 1'b1, "R5 done after sweep", 32'(done), 32'h1);
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
      pat_load = 1'b0; pat_data = '0; mask_load = 1'b0; mask_data = '0;
      start = 1'b0; serial_mode = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(hit_vec == '0 && hist_vec == '0, "R1 vectors", 32'(hit_vec), 32'h0);
      chk(!busy && !done && !any_hit && first_hit == '0, "R1 flags",
          {busy, done, any_hit, 29'(first_hit)}, 32'h0);

      // fill the table: R2
      for (int i = 0; i < W; i++) begin
         logic [B-1:0] v;
         v = B'(i * 29 + 7);
         if (i == 3 || i == 9) v = 8'hA5;
         if (i == 12) v = 8'hA4;
         m_mem[i] = v;
         wr_en = 1'b1; wr_addr = AW'(i); wr_data = v;
         @(negedge clk);
      end
      wr_en = 1'b0;
      rd_addr = AW'(5);
      #0;
      chk(rd_data == m_mem[5], "R2 readback", 32'(rd_data), 32'(m_mem[5]));
      rd_addr = AW'(12);
      #0;
      chk(rd_data == 8'hA4, "R2 readback", 32'(rd_data), 32'hA4);

      // full mask, both modes (R3, R5)
      load(8'hA5, 8'hFF);
      search(1'b0);
      search(1'b1);
      // column 0 masked off adds entry 12 (R4)
      load(8'hA5, 8'hFE);
      search(1'b1);
      search(1'b0);
      // R10 read back the first hit
      rd_addr = first_hit;
      #0;
      chk(rd_data == m_mem[lowest(m_ind)], "R10 first-hit readback", 32'(rd_data), 32'(m_mem[lowest(m_ind)]));
      // empty mask: every entry hits (R4)
      load(8'h3C, 8'h00);
      search(1'b1);
      search(1'b0);
      // absent pattern: no hit (R9)
      load(8'h00, 8'hFF);
      search(1'b0);
      search(1'b1);
      // half mask
      load(8'hA0, 8'hF0);
      search(1'b1);
      search(1'b0);

      // R8: commands during a sweep are ignored
      begin
         exp_t e;
         e.hits = model_hits(); e.hist = m_ind;
         exp_q.push_back(e);
         m_ind = e.hits;
         start = 1'b1; serial_mode = 1'b1;
         @(negedge clk);
         start = 1'b0;
         @(negedge clk);
         pat_load = 1'b1; pat_data = 8'h5A; mask_load = 1'b1; mask_data = 8'h0F;
         start = 1'b1; serial_mode = 1'b0;
         @(negedge clk);
         pat_load = 1'b0; mask_load = 1'b0; start = 1'b0;
         while (busy) @(negedge clk);
         @(negedge clk);
         chk(exp_q.size() == 0, "R8 no pending", 32'(exp_q.size()), 32'h0);
      end
      search(1'b0);
      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R8 queue drained", 32'(exp_q.size()), 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule